// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the clocked front end of a pipelined burst SRAM. On each rising clock edge it samples an address, three chip selects, two address strobes (one meant for a processor, one for a cache controller), a burst-step input, and the write controls. It then reads or writes a behavioural array made of four 9-bit lanes. Read data leaves through an output register together with a drive flag, which tells the pad logic whether the shared data bus should be driven or left in high impedance.

A strobe starts an access, and its low two address bits seed a 2-bit wraparound burst counter. Later edges with no strobe continue the access: the counter steps when the step input is low and holds when it is high. The step order is either linear or interleaved. Write control works differently for the two strobes. A processor-strobed access always opens as a read and takes its write on the following edge. A controller-strobed access writes on the same edge that carries the strobe. The output drive follows double-cycle deselect timing. A sleep input quiets the block after two edges and wakes it two edges after release.

Top module: `burst_sram_front`

## Requirements
- R1: When both strobes are low on an edge with `sel_a_n` low, the processor strobe wins. The access starts as a read, and the write controls on that edge have no effect on the array.
- R2: The processor strobe is ignored while `sel_a_n` is high. With the controller strobe high, such an edge continues the running burst and does not deselect it.
- R3: A read issued on edge k, with all selects active (`sel_a_n` low, `sel_b` high, `sel_c_n` low) and no write enabled, appears on `rd_data` with `rd_oe` high after edge k+1, provided `out_en_n` is low.
- R4: A processor-strobed access ignores the write controls on its strobe edge. The write is taken on the next edge, at the same address when `step_n` is high.
- R5: A controller strobe with the processor strobe high and the selects active writes on that same edge when the write controls enable any lane.
- R6: Lane i is `wr_data[9i+8:9i]` and is controlled by `lane_sel_n[i]`. `wr_all_n` low writes all four lanes. Otherwise, with `wr_lane_en_n` low, each lane whose select bit is low is written. An edge on which no lane is enabled is a read. Lanes that are not written keep their contents.
- R7: With `burst_ilv` low, the n-th continued address has low bits equal to (start + n) mod 4. The upper address bits stay those of the strobe.
- R8: With `burst_ilv` high, the n-th continued address has low bits equal to start XOR n.
- R9: A continue edge with `step_n` high reuses the current address (the burst is suspended).
- R10: After a deselect edge k (controller strobe low with `sel_a_n` high), `rd_oe` may still be high after edge k+1 but is low after edge k+2. The first cycle of an access that follows a deselect is high-Z.
- R11: In the cycle after an edge that takes a write, `rd_oe` is low whatever `out_en_n` is.
- R12: `out_en_n` high forces `rd_oe` low at once, without waiting for a clock.
- R13: `sleep` held high for two edges forces `rd_oe` low and makes strobes ignored, while the array keeps its contents. After `sleep` falls, strobes are ignored for two more edges.
- R14: A synchronous active-low reset leaves the block deselected, with `rd_oe` low, and no burst continues after the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address, sampled with a strobe |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step on continue edges, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, asynchronous, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request, active high |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_oe | output | 1 | High when the data bus should be driven |

## Verification
The main read/write path is exercised by a table that mixes both strobe kinds with four write-control patterns: all lanes, a single lane, two lanes, and enables present but selecting no lane. Each entry is read back against a lane-masked model, which separates a wrong lane decode from a write that lands on the wrong edge. The processor-strobed entries present all-lane garbage on the strobe edge, so any write taken too early corrupts the unselected lanes. Bursts start from an odd low address so that the linear and interleaved sequences differ from the second step on. Directed cases place suspends, ignored strobes, deselects, writes, sleep edges and reset at exact edges, and check the drive flag on each side of them.

// File: rtl/bsram_pkg.sv
// Shared definitions for the burst SRAM front end.
package bsram_pkg;

    // Width of the wraparound burst counter; fixed by the burst behaviour.
    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_ord_e;

    // Low address bits for step `cnt` of a burst that began at `start`.
    function automatic logic [BURST_W-1:0] burst_lsb(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input burst_ord_e         ord
    );
        if (ord == ORD_INTERLEAVE) return start ^ cnt;
        return start + cnt;
    endfunction

endpackage

// File: rtl/bsram_lane_mask.sv
// Decodes the write controls into a per-lane write mask.
// Assumes active-low controls; the all-lane write overrides the per-lane path.
module bsram_lane_mask #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_mask
);

    // Mask selection: global write, per-lane write, or none (read).
    always_comb begin
        if (!wr_all_n)          lane_mask = '1;
        else if (!wr_lane_en_n) lane_mask = ~lane_sel_n;
        else                    lane_mask = '0;
    end

endmodule

// File: rtl/bsram_burst_seq.sv
// Burst address generator: holds the start offset and step count and
// produces the low address bits used on the current edge.
// Assumes `load` and `step` are never high together (the controller ensures it).
module bsram_burst_seq
    import bsram_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  burst_ord_e         ord,
    input  logic [BURST_W-1:0] ld_lsb,
    output logic [BURST_W-1:0] cur_lsb
);

    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nxt;

    // Count in effect on this edge after an optional step.
    always_comb begin
        cnt_nxt = step ? cnt_q + 1'b1 : cnt_q;
        cur_lsb = load ? ld_lsb : burst_lsb(start_q, cnt_nxt, ord);
    end

    // Capture the start on a strobe, otherwise keep the stepped count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            start_q <= ld_lsb;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_nxt;
        end
    end

endmodule

// File: rtl/bsram_access_ctrl.sv
// Access decoder: resolves strobe priority and chip selects, tracks whether
// a burst is open and its upper address, and issues this edge's read or write.
// Assumes `dozing` already carries the two-edge sleep delay.
module bsram_access_ctrl #(
    parameter int LANES = 4,
    parameter int HW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             dozing,
    input  logic [LANES-1:0] lane_mask,
    input  logic [HW-1:0]    addr_hi,
    output logic             load,
    output logic             cont,
    output logic [HW-1:0]    acc_hi,
    output logic [LANES-1:0] acc_we,
    output logic             acc_rd
);

    logic          open_q;
    logic [HW-1:0] base_q;
    logic          cpu_seen;
    logic          ctl_seen;
    logic          selected;
    logic          desel;

    // Strobe priority, chip-select qualification and sleep gating.
    always_comb begin
        cpu_seen = !dozing && !cpu_strobe_n && !sel_a_n;
        ctl_seen = !dozing && !cpu_seen && !ctl_strobe_n;
        selected = !sel_a_n && sel_b && !sel_c_n;
        load     = (cpu_seen || ctl_seen) && selected;
        desel    = dozing || ((cpu_seen || ctl_seen) && !selected);
        cont     = !dozing && !cpu_seen && !ctl_seen && open_q;
        acc_we   = (cpu_seen || !(load || cont)) ? '0 : lane_mask;
        acc_rd   = (load || cont) && (acc_we == '0);
        acc_hi   = load ? addr_hi : base_q;
    end

    // Burst-open flag and captured upper address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            base_q <= '0;
        end else begin
            if (load)       open_q <= 1'b1;
            else if (desel) open_q <= 1'b0;
            if (load)       base_q <= addr_hi;
        end
    end

endmodule

// File: rtl/bsram_array.sv
// Behavioural lane-split memory with per-lane write enables and a
// registered read port. Contents are not reset.
module bsram_array #(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    re,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] q;

        // Lane write on its own enable.
        always_ff @(posedge clk) begin
            if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Lane read into the output register.
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= '0;
            else if (re) q <= cells[raddr];
        end

        assign rdata[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/burst_sram_front.sv
// Top of the pipelined burst SRAM front end. An access issued on edge k is
// read out on edge k+1; the drive flag tracks double-cycle deselect, write
// turnaround, the asynchronous output enable and a two-edge sleep delay.
// Assumes AW >= 3 and that burst_ilv is static while a burst is open.
module burst_sram_front #(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    cpu_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    step_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_oe
);
    import bsram_pkg::*;

    localparam int HW = AW - BURST_W;

    logic [LANES-1:0]   lane_mask;
    logic               load;
    logic               cont;
    logic [HW-1:0]      acc_hi;
    logic [LANES-1:0]   acc_we;
    logic               acc_rd;
    logic [BURST_W-1:0] cur_lsb;
    logic [AW-1:0]      acc_addr;
    logic [1:0]         sleep_sh;
    logic               dozing;
    logic               rd_q;
    logic [AW-1:0]      rd_addr_q;
    logic               valid_q;
    logic               wr_q;

    assign dozing   = sleep_sh[1];
    assign acc_addr = {acc_hi, cur_lsb};

    bsram_lane_mask #(.LANES(LANES)) u_mask (
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .lane_sel_n   (lane_sel_n),
        .lane_mask    (lane_mask)
    );

    bsram_access_ctrl #(.LANES(LANES), .HW(HW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .dozing       (dozing),
        .lane_mask    (lane_mask),
        .addr_hi      (addr[AW-1:BURST_W]),
        .load         (load),
        .cont         (cont),
        .acc_hi       (acc_hi),
        .acc_we       (acc_we),
        .acc_rd       (acc_rd)
    );

    bsram_burst_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (cont && !step_n),
        .ord     (burst_ord_e'(burst_ilv)),
        .ld_lsb  (addr[BURST_W-1:0]),
        .cur_lsb (cur_lsb)
    );

    bsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_we),
        .waddr (acc_addr),
        .wdata (wr_data),
        .re    (rd_q),
        .raddr (rd_addr_q),
        .rdata (rd_data)
    );

    // Two-edge sleep entry and exit delay.
    always_ff @(posedge clk) begin
        if (!rst_n) sleep_sh <= '0;
        else        sleep_sh <= {sleep_sh[0], sleep};
    end

    // Address stage of the read pipeline plus write-turnaround flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            rd_addr_q <= '0;
            wr_q      <= 1'b0;
        end else begin
            rd_q      <= acc_rd;
            wr_q      <= |acc_we;
            if (acc_rd) rd_addr_q <= acc_addr;
        end
    end

    // Output stage: read data is valid one edge after its address stage.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= rd_q;
    end

    // Bus drive: valid data, no write in flight, enabled, awake.
    assign rd_oe = valid_q && !wr_q && !out_en_n && !dozing;

endmodule

// File: rtl/burst_sram_front_chk.sv
// Protocol checker for the burst SRAM front end, attached by bind.
module burst_sram_front_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_a_n,
    input logic sel_b,
    input logic sel_c_n,
    input logic cpu_strobe_n,
    input logic ctl_strobe_n,
    input logic wr_all_n,
    input logic out_en_n,
    input logic sleep,
    input logic rd_oe
);

    // R14: reset leaves the bus undriven.
    a_r14_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !rd_oe);

    // R12: a high output enable keeps the bus off.
    a_r12_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rd_oe);

    // R10: the bus is released two edges after a deselect.
    a_r10_dcd_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strobe_n && sel_a_n) |-> ##2 !rd_oe);

    // R11: a controller-strobed global write turns the bus off in the next cycle.
    a_r11_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe_n && !ctl_strobe_n && !sel_a_n && sel_b && !sel_c_n && !wr_all_n)
        |=> !rd_oe);

    // R13: sleep held for two edges silences the bus.
    a_r13_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |=> !rd_oe);

endmodule

bind burst_sram_front burst_sram_front_chk u_chk (.*);

// File: tb/burst_sram_front_bench.sv
module burst_sram_front_bench;
    localparam int AW = 8, LANES = 4, LANE_W = 9, DW = LANES * LANE_W;

    typedef struct packed {
        logic          cpu;
        logic [AW-1:0] a;
        logic          gw_n;
        logic          be_n;
        logic [3:0]    bs_n;
        logic [DW-1:0] d;
    } vec_t;

    // Write vectors: strobe kind, address, write controls, data.
    localparam vec_t VECS [9] = '{
        '{1'b0, 8'h20, 1'b0, 1'b1, 4'hF, 36'h1_2345_6789},
        '{1'b0, 8'h21, 1'b0, 1'b1, 4'hF, 36'hA_BCDE_F012},
        '{1'b0, 8'h20, 1'b1, 1'b0, 4'hE, 36'h0_0000_01FF},
        '{1'b1, 8'h21, 1'b1, 1'b0, 4'h5, 36'hF_FFFF_FFFF},
        '{1'b1, 8'h22, 1'b0, 1'b1, 4'hF, 36'h5_5555_5555},
        '{1'b0, 8'h22, 1'b1, 1'b1, 4'h0, 36'h0_0000_0000},
        '{1'b0, 8'h22, 1'b1, 1'b0, 4'hF, 36'h3_3333_3333},
        '{1'b0, 8'h23, 1'b0, 1'b1, 4'hF, 36'h9_8765_4321},
        '{1'b1, 8'h23, 1'b1, 1'b0, 4'hB, 36'h0_07FC_0000}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, sel_a_n, sel_b, sel_c_n, cpu_strobe_n, ctl_strobe_n;
    logic          step_n, wr_all_n, wr_lane_en_n, out_en_n, burst_ilv, sleep;
    logic [3:0]    lane_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_oe;
    logic [DW-1:0] ref_mem [1 << AW];
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    burst_sram_front #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_burst_sram_front (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
        .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .burst_ilv(burst_ilv),
        .sleep(sleep), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; step_n = 1'b1;
        wr_all_n = 1'b1; wr_lane_en_n = 1'b1; lane_sel_n = 4'hF;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    // Lane mask per R6, applied to the reference model.
    task automatic ref_write(input logic [AW-1:0] a, input logic gw_n, input logic be_n,
                             input logic [3:0] bs_n, input logic [DW-1:0] d);
        for (int i = 0; i < LANES; i++) begin
            if (!gw_n || (!be_n && !bs_n[i]))
                ref_mem[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
        end
    endtask

    task automatic ctl_read(input logic [AW-1:0] a);
        idle();
        ctl_strobe_n = 1'b0;
        addr = a;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input string req);
        ctl_read(a);
        tick();
        idle();
        tick();
        chk1(req, rd_oe, 1'b1);
        chk(req, rd_data, ref_mem[a]);
    endtask

    task automatic ctl_write(input logic [AW-1:0] a, input logic gw_n, input logic be_n,
                             input logic [3:0] bs_n, input logic [DW-1:0] d);
        idle();
        ctl_strobe_n = 1'b0; addr = a;
        wr_all_n = gw_n; wr_lane_en_n = be_n; lane_sel_n = bs_n; wr_data = d;
        tick();
        ref_write(a, gw_n, be_n, bs_n, d);
        idle();
    endtask

    // Processor-strobed write: all-lane garbage on the strobe edge must be ignored (R4).
    task automatic cpu_write(input logic [AW-1:0] a, input logic gw_n, input logic be_n,
                             input logic [3:0] bs_n, input logic [DW-1:0] d);
        idle();
        cpu_strobe_n = 1'b0; addr = a;
        wr_all_n = 1'b0; wr_lane_en_n = 1'b0; lane_sel_n = 4'h0; wr_data = ~d;
        tick();
        idle();
        wr_all_n = gw_n; wr_lane_en_n = be_n; lane_sel_n = bs_n; wr_data = d;
        tick();
        ref_write(a, gw_n, be_n, bs_n, d);
        idle();
    endtask

    task automatic burst_run(input logic ilv, input string req);
        burst_ilv = ilv;
        ctl_read(8'h31);
        tick();
        idle();
        step_n = 1'b0;
        for (int j = 0; j < 4; j++) begin
            logic [1:0] lsb;
            tick();
            lsb = ilv ? (2'd1 ^ 2'(j)) : (2'd1 + 2'(j));
            chk(req, rd_data, ref_mem[{6'h0C, lsb}]);
        end
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idle(); out_en_n = 1'b0; burst_ilv = 1'b0; sleep = 1'b0;
        addr = '0; wr_data = '0;
        tick(); tick(); tick();
        chk1("R14 in reset", rd_oe, 1'b0);
        rst_n = 1'b1;
        tick();
        chk1("R14 after release", rd_oe, 1'b0);

        // Table: R3 read latency, R4/R5 write edges, R6 lane masks.
        for (int i = 0; i < 9; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.cpu) cpu_write(v.a, v.gw_n, v.be_n, v.bs_n, v.d);
            else       ctl_write(v.a, v.gw_n, v.be_n, v.bs_n, v.d);
            rd_check(v.a, v.cpu ? "R4 R6 R3" : "R5 R6 R3");
        end

        for (int i = 0; i < 4; i++)
            ctl_write(AW'(8'h30 + i), 1'b0, 1'b1, 4'hF, 36'h0_A5A5_0000 + DW'(i * 36'h1_0101));

        burst_run(1'b0, "R7 linear");
        burst_run(1'b1, "R8 interleaved");
        burst_ilv = 1'b0;

        // R9: suspend repeats the address.
        ctl_read(8'h32);
        tick();
        idle();
        tick();
        step_n = 1'b0;
        tick();
        chk("R9 suspend", rd_data, ref_mem[8'h32]);
        tick();
        chk("R9 resume", rd_data, ref_mem[8'h33]);
        idle();

        // R2: processor strobe with sel_a_n high is ignored; burst continues.
        ctl_read(8'h30);
        tick();
        idle();
        cpu_strobe_n = 1'b0; sel_a_n = 1'b1; step_n = 1'b0;
        tick();
        idle();
        tick();
        chk1("R2 still driven", rd_oe, 1'b1);
        chk("R2 continued", rd_data, ref_mem[8'h31]);

        // R1: both strobes low, processor wins; write controls ignored.
        idle();
        cpu_strobe_n = 1'b0; ctl_strobe_n = 1'b0; addr = 8'h32;
        wr_all_n = 1'b0; wr_data = 36'hF_0F0F_0F0F;
        tick();
        idle();
        tick();
        chk1("R1 read driven", rd_oe, 1'b1);
        chk("R1 no write", rd_data, ref_mem[8'h32]);

        // R10: double-cycle deselect and first-cycle high-Z.
        rd_check(8'h31, "R3");
        idle();
        ctl_strobe_n = 1'b0; sel_a_n = 1'b1;
        tick();
        chk1("R10 held one cycle", rd_oe, 1'b1);
        idle();
        tick();
        chk1("R10 released", rd_oe, 1'b0);
        ctl_read(8'h33);
        tick();
        chk1("R10 first cycle", rd_oe, 1'b0);
        idle();
        tick();
        chk1("R10 then driven", rd_oe, 1'b1);
        chk("R10 data", rd_data, ref_mem[8'h33]);

        // R11: write turns the bus off even with out_en_n low.
        ctl_write(8'h34, 1'b0, 1'b1, 4'hF, 36'h7_7777_7777);
        chk1("R11 write hiz", rd_oe, 1'b0);
        rd_check(8'h34, "R11");

        // R12: asynchronous output enable.
        out_en_n = 1'b1;
        #1;
        chk1("R12 off", rd_oe, 1'b0);
        out_en_n = 1'b0;
        #1;
        chk1("R12 on", rd_oe, 1'b1);

        // R13: sleep entry, ignored write, exit delay.
        sleep = 1'b1;
        tick();
        chk1("R13 entry delay", rd_oe, 1'b1);
        tick();
        chk1("R13 asleep", rd_oe, 1'b0);
        idle();
        ctl_strobe_n = 1'b0; addr = 8'h34; wr_all_n = 1'b0; wr_data = '0;
        tick();
        idle();
        tick();
        sleep = 1'b0;
        tick();
        ctl_read(8'h34);
        tick();
        idle();
        tick();
        chk1("R13 exit delay", rd_oe, 1'b0);
        rd_check(8'h34, "R13 contents kept");

        // R14: reset during a driven read.
        rd_check(8'h30, "R3");
        rst_n = 1'b0;
        tick();
        chk1("R14 mid-run", rd_oe, 1'b0);
        rst_n = 1'b1;
        tick();
        tick();
        chk1("R14 no burst after", rd_oe, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule